// File: doc/BRIEF.md
# Interlace-Capable Video Timing Generator

This block produces the raster strobes for a video output: horizontal sync, horizontal blank, vertical sync, vertical blank, an active-picture flag and a field identifier. A pixel counter and a line counter walk the raster. Every strobe is decoded from those counters and from a bank of programmed timing values. Two banks are supplied, one for the even field and one for the odd field. With interlace on, the generator alternates between them field by field. With interlace off, it repeats the even-field bank as progressive frames.

The vertical blank and vertical sync edges can sit at any pixel within a line, so they need not coincide with a line start. Those edge positions, and the line count, may differ between the two fields. Both banks and the interlace choice pass through shadow copies. A change written while the raster is running takes effect only when the current frame ends, so the output never mixes two timings within one frame.

Top module: `vtg_interlace_timing`

## Requirements
- R1: While `enable_i` is low, every output is 0 and the raster is parked at pixel 0 of line 0 in field 0. One clock edge after `enable_i` is first seen high, the outputs show pixel 0 of line 0 of field 0. That position lies in the active picture.
- R2: A line lasts HSIZE cycles, with pixels numbered 0 to HSIZE-1. `hblank_o` is high exactly for pixel indices at or above the active width.
- R3: A field lasts VSIZE lines. `vblank_o` rises at the point (line = active height, pixel = vblank-on pixel). It falls at the point (line = VSIZE-1, pixel = vblank-off pixel) of the same field. An off pixel of HSIZE or more keeps it high until the field wraps.
- R4: `vsync_o` is high from the point (vsync-on line, vsync-on pixel), inclusive, up to the point (vsync-off line, vsync-off pixel), exclusive. Points are ordered by line first and pixel second.
- R5: `hsync_o` is high on every line for pixel indices from the hsync-on pixel, inclusive, up to the hsync-off pixel, exclusive.
- R6: `active_o` is high exactly when both `hblank_o` and `vblank_o` are low.
- R7: With interlace on, `field_id_o` toggles at the end of every field, so the even field reads 0 and the odd field reads 1. With interlace off, `field_id_o` stays 0.
- R8: During an odd field, all timing comes from `f1_regs_i`, including its own HSIZE and VSIZE. During an even field, or with interlace off, all timing comes from `f0_regs_i`, and `f1_regs_i` has no effect.
- R9: Changes to `f0_regs_i`, `f1_regs_i` or `interlace_i` made while running take effect only at a frame boundary. With interlace on, that is the end of an odd field; with interlace off, it is the end of every field. While disabled, they take effect immediately.
- R10: Each bank packs twelve CW-bit values, with value k at bits [k*CW+CW-1 : k*CW]. The order of k from 0 to 11 is: HSIZE, VSIZE, active width, active height, hsync-on pixel, hsync-off pixel, vblank-on pixel, vblank-off pixel, vsync-on line, vsync-on pixel, vsync-off line, vsync-off pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run the raster; low parks it and silences the outputs |
| interlace_i | input | 1 | 1 selects alternating even and odd fields |
| f0_regs_i | input | 12*CW | Even-field timing bank, layout per R10 |
| f1_regs_i | input | 12*CW | Odd-field timing bank, layout per R10 |
| hsync_o | output | 1 | Horizontal sync |
| hblank_o | output | 1 | Horizontal blank |
| vsync_o | output | 1 | Vertical sync |
| vblank_o | output | 1 | Vertical blank |
| active_o | output | 1 | Active picture |
| field_id_o | output | 1 | 0 for the even field, 1 for the odd field |

## Verification
All strobes are decoded without delay from the registered position, so each output reflects the position reached at the latest rising edge. The bench updates its position model right after each rising edge and compares all six outputs at the following falling edge. A rising `enable_i` shows pixel 0 one edge later, and a falling one silences the outputs one edge later. Timing changes become visible on the first cycle after the frame-end edge. For that reason the model's own shadow copies are reloaded only at that edge. Field lengths are also measured from `field_id_o` and compared against HSIZE*VSIZE of each bank.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int VTG_NREG   = 12;
  localparam int VTG_CW_DEF = 12;

  // slot index of each timing value inside a packed bank
  localparam int RI_HSIZE     = 0;
  localparam int RI_VSIZE     = 1;
  localparam int RI_ACT_W     = 2;
  localparam int RI_ACT_H     = 3;
  localparam int RI_HS_ON     = 4;
  localparam int RI_HS_OFF    = 5;
  localparam int RI_VB_ON_PX  = 6;
  localparam int RI_VB_OFF_PX = 7;
  localparam int RI_VS_ON_LN  = 8;
  localparam int RI_VS_ON_PX  = 9;
  localparam int RI_VS_OFF_LN = 10;
  localparam int RI_VS_OFF_PX = 11;
endpackage

// File: rtl/vtg_shadow.sv
module vtg_shadow #(
  parameter int CW   = vtg_pkg::VTG_CW_DEF,
  parameter int NREG = vtg_pkg::VTG_NREG,
  localparam int BW  = CW * NREG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] f0_in,
  input  logic [BW-1:0] f1_in,
  input  logic          il_in,
  output logic [BW-1:0] f0_sh,
  output logic [BW-1:0] f1_sh,
  output logic          il_sh
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f0_sh <= '0;
      f1_sh <= '0;
      il_sh <= 1'b0;
    end else if (load) begin
      f0_sh <= f0_in;
      f1_sh <= f1_in;
      il_sh <= il_in;
    end
  end

  // R9: the copies move only on a load cycle
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(f0_sh) && $stable(f1_sh) && $stable(il_sh)));
endmodule

// File: rtl/vtg_bank_sel.sv
module vtg_bank_sel #(
  parameter int CW   = vtg_pkg::VTG_CW_DEF,
  parameter int NREG = vtg_pkg::VTG_NREG,
  localparam int BW  = CW * NREG
) (
  input  logic          field,
  input  logic [BW-1:0] f0_sh,
  input  logic [BW-1:0] f1_sh,
  output logic [CW-1:0] cur [NREG]
);
  logic [BW-1:0] sel;
  assign sel = field ? f1_sh : f0_sh;

  for (genvar k = 0; k < NREG; k++) begin : g_slot
    assign cur[k] = sel[k*CW +: CW];
  end
endmodule

// File: rtl/vtg_counter.sv
module vtg_counter #(
  parameter int CW = vtg_pkg::VTG_CW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          il_sh,
  input  logic [CW-1:0] hsize,
  input  logic [CW-1:0] vsize,
  output logic          running,
  output logic [CW-1:0] h,
  output logic [CW-1:0] v,
  output logic          field,
  output logic          eof_field,
  output logic          eof_frame
);
  logic h_last, v_last;

  assign h_last    = (h == hsize - CW'(1));
  assign v_last    = (v == vsize - CW'(1));
  assign eof_field = running && h_last && v_last;
  assign eof_frame = eof_field && (!il_sh || field);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      h       <= '0;
      v       <= '0;
      field   <= 1'b0;
    end else begin
      running <= enable;
      if (!running) begin
        h     <= '0;
        v     <= '0;
        field <= 1'b0;
      end else if (h_last) begin
        h <= '0;
        if (v_last) begin
          v     <= '0;
          field <= il_sh ? ~field : 1'b0;
        end else begin
          v <= v + CW'(1);
        end
      end else begin
        h <= h + CW'(1);
      end
    end
  end

  // R2: pixel index stays inside the line
  p_h_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (h < hsize));
  // R2: a full line wraps to pixel 0
  p_line_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && h_last) |=> (h == '0));
  // R7: interlaced field ends flip the field id
  p_field_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_field && il_sh) |=> (field != $past(field)));
  // R7: progressive keeps field 0
  p_prog_field0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !il_sh) |-> !field);
endmodule

// File: rtl/vtg_decode.sv
module vtg_decode #(
  parameter int CW = vtg_pkg::VTG_CW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          running,
  input  logic          field,
  input  logic [CW-1:0] h,
  input  logic [CW-1:0] v,
  input  logic [CW-1:0] vsize,
  input  logic [CW-1:0] act_w,
  input  logic [CW-1:0] act_h,
  input  logic [CW-1:0] hs_on,
  input  logic [CW-1:0] hs_off,
  input  logic [CW-1:0] vb_on_px,
  input  logic [CW-1:0] vb_off_px,
  input  logic [CW-1:0] vs_on_ln,
  input  logic [CW-1:0] vs_on_px,
  input  logic [CW-1:0] vs_off_ln,
  input  logic [CW-1:0] vs_off_px,
  output logic          hsync,
  output logic          hblank,
  output logic          vsync,
  output logic          vblank,
  output logic          active,
  output logic          field_id
);
  // true when raster point (lv, lh) is at or past point (rv, rh)
  function automatic logic at_or_after(input logic [CW-1:0] lv, input logic [CW-1:0] lh,
                                       input logic [CW-1:0] rv, input logic [CW-1:0] rh);
    return (lv > rv) || ((lv == rv) && (lh >= rh));
  endfunction

  logic hb_raw, vb_raw, vs_raw, hs_raw;

  assign hb_raw = (h >= act_w);
  assign hs_raw = (h >= hs_on) && (h < hs_off);
  assign vb_raw = at_or_after(v, h, act_h, vb_on_px)
               && !at_or_after(v, h, vsize - CW'(1), vb_off_px);
  assign vs_raw = at_or_after(v, h, vs_on_ln, vs_on_px)
               && !at_or_after(v, h, vs_off_ln, vs_off_px);

  assign hblank   = running && hb_raw;
  assign vblank   = running && vb_raw;
  assign hsync    = running && hs_raw;
  assign vsync    = running && vs_raw;
  assign active   = running && !hb_raw && !vb_raw;
  assign field_id = running && field;

  // R6: the raster origin is active whenever the active area is non-empty
  p_origin_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && h == '0 && v == '0 && act_w != '0 && act_h != '0) |-> active);
endmodule

// File: rtl/vtg_interlace_timing.sv
module vtg_interlace_timing #(
  parameter int CW   = vtg_pkg::VTG_CW_DEF,
  parameter int NREG = vtg_pkg::VTG_NREG,
  localparam int BW  = CW * NREG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic          interlace_i,
  input  logic [BW-1:0] f0_regs_i,
  input  logic [BW-1:0] f1_regs_i,
  output logic          hsync_o,
  output logic          hblank_o,
  output logic          vsync_o,
  output logic          vblank_o,
  output logic          active_o,
  output logic          field_id_o
);
  import vtg_pkg::*;

  logic [BW-1:0] f0_sh, f1_sh;
  logic          il_sh;
  logic          running, field, eof_field, eof_frame, shadow_load;
  logic [CW-1:0] h, v;
  logic [CW-1:0] cur [NREG];

  assign shadow_load = !running || eof_frame;

  vtg_shadow #(.CW(CW), .NREG(NREG)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(shadow_load),
    .f0_in(f0_regs_i), .f1_in(f1_regs_i), .il_in(interlace_i),
    .f0_sh(f0_sh), .f1_sh(f1_sh), .il_sh(il_sh)
  );

  vtg_bank_sel #(.CW(CW), .NREG(NREG)) u_bank_sel (
    .field(field), .f0_sh(f0_sh), .f1_sh(f1_sh), .cur(cur)
  );

  vtg_counter #(.CW(CW)) u_counter (
    .clk(clk), .rst_n(rst_n), .enable(enable_i), .il_sh(il_sh),
    .hsize(cur[RI_HSIZE]), .vsize(cur[RI_VSIZE]),
    .running(running), .h(h), .v(v), .field(field),
    .eof_field(eof_field), .eof_frame(eof_frame)
  );

  vtg_decode #(.CW(CW)) u_decode (
    .clk(clk), .rst_n(rst_n), .running(running), .field(field),
    .h(h), .v(v), .vsize(cur[RI_VSIZE]),
    .act_w(cur[RI_ACT_W]), .act_h(cur[RI_ACT_H]),
    .hs_on(cur[RI_HS_ON]), .hs_off(cur[RI_HS_OFF]),
    .vb_on_px(cur[RI_VB_ON_PX]), .vb_off_px(cur[RI_VB_OFF_PX]),
    .vs_on_ln(cur[RI_VS_ON_LN]), .vs_on_px(cur[RI_VS_ON_PX]),
    .vs_off_ln(cur[RI_VS_OFF_LN]), .vs_off_px(cur[RI_VS_OFF_PX]),
    .hsync(hsync_o), .hblank(hblank_o), .vsync(vsync_o),
    .vblank(vblank_o), .active(active_o), .field_id(field_id_o)
  );

  // R1: a parked raster drives nothing
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !(hsync_o || hblank_o || vsync_o || vblank_o || active_o || field_id_o));
  // R9: a running frame keeps its bank until the frame ends
  p_frame_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !eof_frame) |=> $stable(f0_sh));
endmodule

// File: tb/test_vtg_interlace_timing.sv
module test_vtg_interlace_timing;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int NR = 12;
  localparam int BW = CW * NR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable_i = 1'b0;
  logic interlace_i = 1'b0;
  logic [BW-1:0] f0_regs_i = '0;
  logic [BW-1:0] f1_regs_i = '0;
  logic hsync_o, hblank_o, vsync_o, vblank_o, active_o, field_id_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  vtg_interlace_timing #(.CW(CW), .NREG(NR)) i_vtg_interlace_timing (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .interlace_i(interlace_i),
    .f0_regs_i(f0_regs_i), .f1_regs_i(f1_regs_i),
    .hsync_o(hsync_o), .hblank_o(hblank_o), .vsync_o(vsync_o),
    .vblank_o(vblank_o), .active_o(active_o), .field_id_o(field_id_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // programmed banks (R10 order) and the model's shadow copies
  int c0[NR], c1[NR], mb0[NR], mb1[NR];
  int m_h = 0, m_v = 0;
  bit m_run = 0, m_fld = 0, m_il = 0;

  task automatic chk(input string req, input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] t=%0t actual=%b expected=%b", req, tag, $time, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", req, tag, $time, act, exp);
    end
  endtask

  task automatic apply_regs();
    for (int k = 0; k < NR; k++) begin
      f0_regs_i[k*CW +: CW] = c0[k][CW-1:0];
      f1_regs_i[k*CW +: CW] = c1[k][CW-1:0];
    end
  endtask

  // advance the position model by one rising edge
  task automatic model_step();
    int hs, vs, nh, nv;
    bit nf, eof_fld, eof_frm;
    if (!rst_n) begin
      m_run = 0; m_h = 0; m_v = 0; m_fld = 0; m_il = 0;
      mb0 = '{default: 0}; mb1 = '{default: 0};
      return;
    end
    hs = m_fld ? mb1[0] : mb0[0];
    vs = m_fld ? mb1[1] : mb0[1];
    eof_fld = m_run && (m_h == hs - 1) && (m_v == vs - 1);
    eof_frm = eof_fld && (!m_il || m_fld);
    nh = m_h; nv = m_v; nf = m_fld;
    if (!m_run) begin
      nh = 0; nv = 0; nf = 0;
    end else if (m_h == hs - 1) begin
      nh = 0;
      if (m_v == vs - 1) begin
        nv = 0;
        nf = m_il ? !m_fld : 1'b0;
      end else nv = m_v + 1;
    end else nh = m_h + 1;
    if (!m_run || eof_frm) begin
      mb0 = c0; mb1 = c1; m_il = interlace_i;
    end
    m_h = nh; m_v = nv; m_fld = nf;
    m_run = enable_i;
  endtask

  // expected strobes from a linear pixel index within the field
  task automatic compare_all(input string tag);
    int b[NR];
    int idx, hs;
    bit e_hb, e_vb, e_vs, e_hsy;
    b = m_fld ? mb1 : mb0;
    hs = b[0];
    idx = m_v * hs + m_h;
    e_hb  = m_run && (m_h >= b[2]);
    e_hsy = m_run && (m_h >= b[4]) && (m_h < b[5]);
    e_vb  = m_run && (idx >= b[3] * hs + b[6]) && (idx < (b[1] - 1) * hs + b[7]);
    e_vs  = m_run && (idx >= b[8] * hs + b[9]) && (idx < b[10] * hs + b[11]);
    chk("R2", tag, hblank_o, e_hb);
    chk("R3", tag, vblank_o, e_vb);
    chk("R4", tag, vsync_o, e_vs);
    chk("R5", tag, hsync_o, e_hsy);
    chk("R6", tag, active_o, m_run && !e_hb && !e_vb);
    chk("R7", tag, field_id_o, m_run && m_fld);
  endtask

  task automatic run_cycles(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all(tag);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "reset", hblank_o | vblank_o | hsync_o | vsync_o | active_o | field_id_o, 1'b0);
    rst_n = 1'b1;
    run_cycles(4, "R1 idle");
    chk("R1", "idle", active_o | hblank_o | field_id_o, 1'b0);
  endtask

  task automatic t_progressive();
    // hsize vsize aw ah hs_on hs_off vb_on vb_off vs_ln vs_px vs_off_ln vs_off_px
    c0 = '{10, 6, 6, 4, 7, 9, 3, 8, 4, 5, 5, 2};
    c1 = '{12, 5, 4, 2, 1, 3, 0, 2, 1, 1, 2, 2};
    apply_regs();
    interlace_i = 1'b0;
    enable_i = 1'b1;
    run_cycles(1, "R1 start");
    chk("R1", "first pixel active", active_o, 1'b1);
    chk("R1", "first pixel field", field_id_o, 1'b0);
    run_cycles(130, "R8 R10 progressive");
  endtask

  task automatic t_shadow();
    run_cycles(17, "R9 pre");
    c0 = '{10, 6, 5, 4, 6, 8, 2, 8, 4, 5, 5, 2};
    apply_regs();
    run_cycles(130, "R9 reg change");
    interlace_i = 1'b1;
    c1 = '{10, 7, 6, 4, 7, 9, 8, 6, 4, 0, 5, 0};
    apply_regs();
    run_cycles(23, "R9 mode change");
  endtask

  task automatic t_interlace();
    int cnt;
    int guard;
    guard = 0;
    while (field_id_o !== 1'b1 && guard < 400) begin
      run_cycles(1, "R8 wait odd"); guard++;
    end
    cnt = 1;
    while (field_id_o === 1'b1 && cnt < 400) begin
      run_cycles(1, "R8 odd"); cnt++;
    end
    cnt--;
    chk_int("R8", "odd field length", cnt, 70);
    cnt = 1;
    while (field_id_o === 1'b0 && cnt < 400) begin
      run_cycles(1, "R8 even"); cnt++;
    end
    cnt--;
    chk_int("R8", "even field length", cnt, 60);
    run_cycles(140, "R7 interlace");
  endtask

  task automatic t_disable();
    run_cycles(9, "R1 pre");
    enable_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      run_cycles(1, "R1 off");
      chk("R1", "disabled quiet",
          hblank_o | vblank_o | hsync_o | vsync_o | active_o | field_id_o, 1'b0);
    end
    enable_i = 1'b1;
    run_cycles(1, "R1 restart");
    chk("R1", "restart origin active", active_o, 1'b1);
    chk("R1", "restart field even", field_id_o, 1'b0);
    run_cycles(80, "R1 run");
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    c0 = '{default: 0};
    c1 = '{default: 0};
    repeat (3) @(negedge clk);
    t_reset();
    t_progressive();
    t_shadow();
    t_interlace();
    t_disable();
    finished = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog expired t=%0t actual=hung expected=done", $time);
      finish_run();
    end
  end
endmodule